// File: doc/BRIEF.md
# Machine-Cycle Clock Prescaler and Phase Sequencer

This block sets the basic timing of a small 8-bit controller core. It runs from one oscillator clock and drives a clock-enable, `tick_o`, which gates the core and the peripherals. In the default standard mode a divide-by-two stage sits in the path, and the enable pulses on every second oscillator cycle. Software can write a single mode bit to bypass the divider. In fast mode the enable stays high and the core runs at the full oscillator rate.

A phase sequencer counts the enabled ticks through six states for each machine cycle. It raises a one-tick strobe on the last state of each cycle. A machine cycle therefore lasts 12 oscillator periods in standard mode and 6 in fast mode. A written mode value is held as pending. It takes effect only on the next rising edge of the divided clock, so a change in either direction never shortens an enable gap. The read port returns the mode that is in effect, not the last value written.

Top module: `mcycle_timing`

## Requirements
- R1: While `rst_ni` is low and right after it is released, `mode_o` is 0 (standard), `state_o` is 0, and `tick_o` and `cycle_end_o` are low.
- R2: In standard mode (`mode_o`=0), `tick_o` toggles on every oscillator cycle, so it is high on exactly one cycle out of two.
- R3: In fast mode (`mode_o`=1), `tick_o` is high on every oscillator cycle.
- R4: `state_o` advances by one on each clock edge where `tick_o` is high and wraps from 5 to 0. It holds its value when `tick_o` is low.
- R5: `cycle_end_o` is high exactly when `tick_o` is high and `state_o` is 5. Consecutive strobes are therefore 12 clocks apart in standard mode and 6 clocks apart in fast mode.
- R6: A write (`mode_we_i`=1 with `mode_wdata_i`: 0 selects standard, 1 selects fast) takes effect on the first divided-clock rising edge after the write edge, and never on the write edge itself. In standard mode this is 1 clock after a write made while `tick_o` is high, and 2 clocks after a write made while `tick_o` is low. When `mode_we_i` is low, `mode_wdata_i` is ignored.
- R7: `mode_o` reports the mode in effect. It keeps the old value while a written value is still pending.
- R8: `tick_o` is never low on two consecutive cycles. On the first cycle that shows a new mode on `mode_o`, `tick_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Write strobe for the mode bit |
| mode_wdata_i | input | 1 | Mode value to write: 0 standard, 1 fast |
| mode_o | output | 1 | Mode currently in effect |
| tick_o | output | 1 | Clock-enable for the core and peripherals |
| state_o | output | 3 | Phase index within the machine cycle, 0 to 5 |
| cycle_end_o | output | 1 | Strobe on the final tick of each machine cycle |

## Verification
The hardest situation to reach is a pending write, where `mode_o` still shows the old mode while a new one waits for the divider. In fast mode the divider phase cannot be seen at the ports. The bench therefore first lines its write up with the visible standard-mode enable. It writes once while `tick_o` is high and once while it is low, and checks the 1-clock and the 2-clock latency. Switching back from fast mode is checked against a window of one or two clocks. In that window the first standard-mode cycle must carry an enable, and two low enables must never follow each other.

// File: rtl/mct_pkg.sv
package mct_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FAST = 1'b1
  } mode_e;
endpackage

// File: rtl/mct_prescale.sv
module mct_prescale
  import mct_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  mode_e wdata_i,
  output mode_e mode_o,
  output logic  tick_o
);
  logic  half_q;
  mode_e pend_q, mode_q;

  // free-running divide-by-two phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= ~half_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pend_q <= MODE_STD;
    else if (we_i) pend_q <= wdata_i;
  end

  // mode adopted only on the divided-clock rising edge (half 0 -> 1)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= MODE_STD;
    else if (!half_q) mode_q <= pend_q;
  end

  assign mode_o = mode_q;
  assign tick_o = (mode_q == MODE_FAST) | half_q;

  assert_std_alternate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STD && tick_o) |=> (!tick_o || mode_q == MODE_FAST));

  assert_switch_on_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> half_q);

  assert_no_double_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> tick_o);

  assert_pending_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q |=> $stable(mode_q));
endmodule

// File: rtl/mct_phase.sv
module mct_phase #(
  parameter int unsigned NUM_STATES = 6,
  localparam int unsigned STATE_W   = $clog2(NUM_STATES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  output logic [STATE_W-1:0] state_o,
  output logic               cycle_end_o
);
  localparam logic [STATE_W-1:0] LastState = STATE_W'(NUM_STATES - 1);

  logic [STATE_W-1:0] state_q;
  logic               at_last;

  assign at_last = (state_q == LastState);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= '0;
    else if (tick_i)  state_q <= at_last ? '0 : state_q + 1'b1;
  end

  assign state_o     = state_q;
  assign cycle_end_o = tick_i & at_last;

  assert_hold_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q));

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !at_last) |=> (state_q == $past(state_q) + 1'b1));

  assert_wrap_after_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_end_o |=> (state_q == '0));

  assert_state_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q <= LastState);
endmodule

// File: rtl/mcycle_timing.sv
module mcycle_timing
  import mct_pkg::*;
#(
  parameter int unsigned NUM_STATES = 6,
  localparam int unsigned STATE_W   = $clog2(NUM_STATES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_we_i,
  input  logic               mode_wdata_i,
  output logic               mode_o,
  output logic [STATE_W-1:0] state_o,
  output logic               tick_o,
  output logic               cycle_end_o
);
  mode_e mode_eff;
  logic  tick;

  mct_prescale i_prescale (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mode_we_i),
    .wdata_i (mode_e'(mode_wdata_i)),
    .mode_o  (mode_eff),
    .tick_o  (tick)
  );

  mct_phase #(.NUM_STATES(NUM_STATES)) i_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .state_o     (state_o),
    .cycle_end_o (cycle_end_o)
  );

  assign mode_o = (mode_eff == MODE_FAST);
  assign tick_o = tick;

  assert_fast_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o |-> tick_o);
endmodule

// File: tb/test_mcycle_timing.sv
module test_mcycle_timing;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_we_i = 1'b0;
  logic       mode_wdata_i = 1'b0;
  logic       mode_o;
  logic [2:0] state_o;
  logic       tick_o;
  logic       cycle_end_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  mcycle_timing i_mcycle_timing (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i),
    .mode_o(mode_o), .state_o(state_o), .tick_o(tick_o), .cycle_end_o(cycle_end_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  // observe n cycles, checking enable, phase and strobe behaviour
  task automatic observe(input int n, input bit fast, input string tag);
    int ticks = 0, ends = 0, bad_alt = 0, bad_st = 0, bad_end = 0, bad_gap = 0;
    int last_end = -1, bad_iv = 0;
    int period = fast ? 6 : 12;
    bit  ptick = tick_o;
    logic [2:0] pst = state_o;
    for (int i = 0; i < n; i++) begin
      step();
      if (tick_o) ticks++;
      if (!fast && tick_o == ptick) bad_alt++;
      if (!tick_o && !ptick) bad_gap++;
      if (ptick) begin
        if (state_o != ((pst == 3'd5) ? 3'd0 : pst + 3'd1)) bad_st++;
      end else if (state_o != pst) bad_st++;
      if (cycle_end_o != (tick_o && state_o == 3'd5)) bad_end++;
      if (cycle_end_o) begin
        ends++;
        if (last_end >= 0 && i - last_end != period) bad_iv++;
        last_end = i;
      end
      ptick = tick_o;
      pst   = state_o;
    end
    chk(ticks == (fast ? n : n / 2), fast ? "R3 tick count" : "R2 tick count", ticks, fast ? n : n / 2);
    chk(bad_alt == 0, "R2 alternation", bad_alt, 0);
    chk(bad_st == 0, "R4 state stepping", bad_st, 0);
    chk(bad_end == 0, "R5 strobe position", bad_end, 0);
    chk(ends == n / period, "R5 strobe count", ends, n / period);
    chk(bad_iv == 0, "R5 strobe interval", bad_iv, 0);
    chk(bad_gap == 0, "R8 no double gap", bad_gap, 0);
    if (tag.len() == 0) $display("observe done");
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) step();
    chk(mode_o == 1'b0 && state_o == 3'd0 && !tick_o && !cycle_end_o, "R1 in reset",
        {mode_o, tick_o, cycle_end_o, state_o}, 0);
    rst_ni = 1'b1;
    step();
    chk(mode_o == 1'b0 && state_o == 3'd0, "R1 after release", {mode_o, state_o}, 0);
  endtask

  task automatic t_standard();
    // data without write strobe must be ignored
    mode_wdata_i = 1'b1;
    observe(24, 1'b0, "std");
    chk(mode_o == 1'b0, "R6 wdata ignored without we", mode_o, 0);
    mode_wdata_i = 1'b0;
    mode_we_i = 1'b1; step(); mode_we_i = 1'b0;
    chk(mode_o == 1'b0, "R7 rewrite same mode", mode_o, 0);
    observe(24, 1'b0, "std2");
  endtask

  task automatic t_fast_when_high();
    while (!tick_o) step();
    mode_we_i = 1'b1; mode_wdata_i = 1'b1;
    step();
    mode_we_i = 1'b0;
    chk(mode_o == 1'b0, "R7 pending not visible", mode_o, 0);
    step();
    chk(mode_o == 1'b1, "R6 one-clock latency", mode_o, 1);
    chk(tick_o == 1'b1, "R8 tick on first new-mode cycle", tick_o, 1);
    observe(36, 1'b1, "fast");
  endtask

  task automatic t_back_to_std();
    int lat = 0;
    mode_we_i = 1'b1; mode_wdata_i = 1'b0;
    step();
    mode_we_i = 1'b0;
    chk(mode_o == 1'b1, "R6 no change on write edge", mode_o, 1);
    while (mode_o && lat < 4) begin step(); lat++; end
    chk(lat >= 1 && lat <= 2, "R6 fast-to-std latency", lat, 2);
    chk(tick_o == 1'b1, "R8 tick on first std cycle", tick_o, 1);
    step();
    chk(tick_o == 1'b0, "R2 gap after switch", tick_o, 0);
    observe(24, 1'b0, "std3");
  endtask

  task automatic t_fast_when_low();
    while (tick_o) step();
    mode_we_i = 1'b1; mode_wdata_i = 1'b1;
    step();
    mode_we_i = 1'b0;
    chk(mode_o == 1'b0, "R7 pending after low-phase write", mode_o, 0);
    step();
    chk(mode_o == 1'b0, "R6 not yet at next edge", mode_o, 0);
    step();
    chk(mode_o == 1'b1, "R6 two-clock latency", mode_o, 1);
    observe(12, 1'b1, "fast2");
  endtask

  initial begin
    step();
    do_reset();
    t_standard();
    t_fast_when_high();
    t_back_to_std();
    t_fast_when_low();
    do_reset();
    observe(12, 1'b0, "std4");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule